// File: doc/BRIEF.md
# Pipe colour matrix converter

This block sits in one display pipe and re-maps the colour of every pixel. Each clock it may accept one pixel made of three 12-bit unsigned channels: channel 0 carries R or Cr, channel 1 carries G or Y, and channel 2 carries B or Cb. The block then does three things in order:

- it adds a signed offset to each input channel;
- it multiplies the offset vector by a programmable 3x3 matrix;
- it adds a second offset to each result row.

The result is rounded to nearest and clamped back to 0..4095. Three pipeline stages give a fixed latency, and the valid flag travels with the data.

Software programs the matrix, the input offsets, the output offsets and a control word through a small write-only register port. Writes go into a staging copy. The copy used by the datapath is refreshed only on a frame-start pulse, so a frame is never converted with a mix of old and new settings. The output offsets have two sources. In explicit mode they come from their own registers. In legacy mode a fixed triplet is used instead, chosen by a YUV-to-RGB bit and a black-level bit; this serves setups that predate output-offset registers. Frame start is expected during blanking, when no pixel is inside the pipeline.

Top module: `csc_pipe`

## Requirements
- R1: A pixel accepted with `in_valid` high appears on the outputs with `out_valid` high exactly 3 clocks later. Back-to-back pixels and gaps keep this latency, and `out_valid` is never high otherwise.
- R2: Output row j equals c[3j]·a0 + c[3j+1]·a1 + c[3j+2]·a2 + post[j], where a_k = input channel k + pre[k]. Row 0 drives `out_ch0` (R/Cr), row 1 drives `out_ch1` (G/Y) and row 2 drives `out_ch2` (B/Cb).
- R3: The sum is kept exact, with 12 fraction bits from the coefficients, until the final step. There it is rounded to the nearest integer, and an exact half rounds upward (0.5 gives 1, 1.5 gives 2, 2.5 gives 3).
- R4: After rounding, a negative result outputs 0 and a result above 4095 outputs 4095.
- R5: The register map is as follows.
  - Addresses 0..8 hold coefficients c0..c8, row-major. Each is 15-bit two's complement with 12 fraction bits (1.0 = 0x1000, range -4.0 to just under 4.0).
  - Addresses 9..11 hold the input offsets for channels 0..2, and addresses 12..14 hold the output offsets for rows 0..2. Offsets are 13-bit two's complement in output LSBs, so half of full scale is 0x800.
  - Address 15 is the control word: bit 0 selects legacy mode, bit 1 is the YUV-to-RGB bit and bit 2 is the black-level bit.
- R6: A register write has no effect on the datapath until the next `frame_start` pulse. A write issued in the same cycle as that pulse waits for the following pulse.
- R7: Reset loads the identity matrix, zero offsets and explicit mode, so pixels pass through unchanged. All-zero offset triplets change nothing.
- R8: In legacy mode the output offsets for rows 0/1/2 are chosen by (YUV-to-RGB, black-level), and the explicit output-offset registers are ignored:
  - (0,0) gives 2048/0/2048;
  - (0,1) gives 2048/256/2048;
  - (1,0) gives 0/0/0;
  - (1,1) gives 256/256/256.
- R9: While `out_valid` is low, `out_ch0..2` keep the value of the last valid output.
- R10: During reset, and in the first cycle after it, `out_valid` and all three output channels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 15 | Register write data |
| frame_start | input | 1 | One-cycle pulse that makes staged settings active |
| in_valid | input | 1 | Input pixel valid |
| in_ch0 | input | 12 | Input R/Cr |
| in_ch1 | input | 12 | Input G/Y |
| in_ch2 | input | 12 | Input B/Cb |
| out_valid | output | 1 | Output pixel valid |
| out_ch0 | output | 12 | Output row 0, R/Cr |
| out_ch1 | output | 12 | Output row 1, G/Y |
| out_ch2 | output | 12 | Output row 2, B/Cb |

## Verification
The assertions check four things on every cycle: the three-clock valid latency, that outputs hold while no pixel leaves, that the active settings change only after a frame-start pulse, and the cleared outputs just after reset. The arithmetic cannot be seen that way. That includes the matrix product with its row order, the half-up rounding, clamping at both ends, and the legacy offset table. The same holds for the rule that a write in the frame-start cycle is deferred. These are shown by the bench's scenarios, each compared against a behavioural model computed with plain integers.

// File: rtl/csc_pkg.sv
// Shared constants and types for the pipe colour matrix converter.
// Assumes a fixed 16-entry register map and three colour channels.
package csc_pkg;
    localparam int ADDR_W    = 4;
    localparam int N_CH      = 3;
    localparam int N_COEF    = N_CH * N_CH;
    localparam int COEF_FRAC = 12;

    // Register map (row-major coefficients first)
    localparam int ADR_PRE0  = 9;
    localparam int ADR_POST0 = 12;
    localparam int ADR_CTRL  = 15;

    // Control word, bit 0 = legacy mode, bit 1 = yuv-to-rgb, bit 2 = black level
    typedef struct packed {
        logic black_lvl;
        logic yuv_to_rgb;
        logic legacy;
    } csc_ctrl_t;
endpackage

// File: rtl/csc_cfg_regs.sv
// Staged and active configuration for the converter.
// Writes land in a staging copy; frame_start copies staging to active.
// Also resolves the row offsets applied after the matrix (explicit or legacy).
// Assumes COEF_W > PIX_W so the write data covers every field.
module csc_cfg_regs
    import csc_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int COEF_W = 15,
    parameter int OFF_W  = PIX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [COEF_W-1:0]        cfg_wdata,
    input  logic                     frame_start,
    output logic signed [COEF_W-1:0] coef_q   [N_COEF],
    output logic signed [OFF_W-1:0]  pre_q    [N_CH],
    output logic signed [OFF_W-1:0]  post_eff [N_CH]
);
    localparam logic signed [COEF_W-1:0] ONE  =
        {{(COEF_W-COEF_FRAC-1){1'b0}}, 1'b1, {COEF_FRAC{1'b0}}};
    localparam logic signed [OFF_W-1:0]  HALF = {2'b01, {(PIX_W-1){1'b0}}};
    localparam logic signed [OFF_W-1:0]  SIXT = {5'b00001, {(PIX_W-4){1'b0}}};

    logic signed [COEF_W-1:0] stg_coef [N_COEF];
    logic signed [OFF_W-1:0]  stg_pre  [N_CH];
    logic signed [OFF_W-1:0]  stg_post [N_CH];
    csc_ctrl_t                stg_ctrl;

    logic signed [OFF_W-1:0]  act_post [N_CH];
    csc_ctrl_t                act_ctrl;
    logic signed [OFF_W-1:0]  leg_post [N_CH];

    // Staging copy: absorbs register writes at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_COEF; i++)
                stg_coef[i] <= (i % (N_CH + 1) == 0) ? ONE : '0;
            for (int i = 0; i < N_CH; i++) begin
                stg_pre[i]  <= '0;
                stg_post[i] <= '0;
            end
            stg_ctrl <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N_COEF; i++)
                if (cfg_addr == ADDR_W'(i))
                    stg_coef[i] <= cfg_wdata;
            for (int i = 0; i < N_CH; i++) begin
                if (cfg_addr == ADDR_W'(ADR_PRE0 + i))
                    stg_pre[i] <= cfg_wdata[OFF_W-1:0];
                if (cfg_addr == ADDR_W'(ADR_POST0 + i))
                    stg_post[i] <= cfg_wdata[OFF_W-1:0];
            end
            if (cfg_addr == ADDR_W'(ADR_CTRL))
                stg_ctrl <= csc_ctrl_t'(cfg_wdata[2:0]);
        end
    end

    // Active copy: refreshed only on the frame-start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_COEF; i++)
                coef_q[i] <= (i % (N_CH + 1) == 0) ? ONE : '0;
            for (int i = 0; i < N_CH; i++) begin
                pre_q[i]    <= '0;
                act_post[i] <= '0;
            end
            act_ctrl <= '0;
        end else if (frame_start) begin
            coef_q   <= stg_coef;
            pre_q    <= stg_pre;
            act_post <= stg_post;
            act_ctrl <= stg_ctrl;
        end
    end

    // Legacy offset triplet picked by the two control bits
    always_comb begin
        case ({act_ctrl.yuv_to_rgb, act_ctrl.black_lvl})
            2'b00:   begin leg_post[0] = HALF; leg_post[1] = '0;   leg_post[2] = HALF; end
            2'b01:   begin leg_post[0] = HALF; leg_post[1] = SIXT; leg_post[2] = HALF; end
            2'b10:   begin leg_post[0] = '0;   leg_post[1] = '0;   leg_post[2] = '0;   end
            default: begin leg_post[0] = SIXT; leg_post[1] = SIXT; leg_post[2] = SIXT; end
        endcase
    end

    // Effective row offsets: legacy table or explicit registers
    always_comb begin
        for (int i = 0; i < N_CH; i++)
            post_eff[i] = act_ctrl.legacy ? leg_post[i] : act_post[i];
    end
endmodule

// File: rtl/csc_pre_add.sv
// Stage 1: adds the signed input offset to each unsigned channel.
// The sum is two bits wider than the pixel, so it cannot overflow.
// Registers load only for valid pixels and hold otherwise.
module csc_pre_add
    import csc_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int OFF_W = PIX_W + 1,
    parameter int SUM_W = PIX_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [PIX_W-1:0]        in_pix [N_CH],
    input  logic signed [OFF_W-1:0] pre    [N_CH],
    output logic                    v_q,
    output logic signed [SUM_W-1:0] sum_q  [N_CH]
);
    logic signed [SUM_W-1:0] sum_d [N_CH];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign sum_d[c] = $signed({2'b00, in_pix[c]}) +
                          $signed({{(SUM_W-OFF_W){pre[c][OFF_W-1]}}, pre[c]});
    end

    // Valid flag for stage 1
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= in_valid;
    end

    // Offset sums, captured for valid pixels only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CH; c++) sum_q[c] <= '0;
        end else if (in_valid) begin
            sum_q <= sum_d;
        end
    end
endmodule

// File: rtl/csc_matrix_mac.sv
// Stage 2: full-precision 3x3 matrix product, one accumulator per row.
// Coefficients are row-major; ACC_W holds the worst case exactly.
module csc_matrix_mac
    import csc_pkg::*;
#(
    parameter int COEF_W = 15,
    parameter int SUM_W  = 14,
    parameter int ACC_W  = SUM_W + COEF_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic signed [SUM_W-1:0]  sum_in [N_CH],
    input  logic signed [COEF_W-1:0] coef   [N_COEF],
    output logic                     v_q,
    output logic signed [ACC_W-1:0]  acc_q  [N_CH]
);
    logic signed [ACC_W-1:0] prod  [N_CH][N_CH];
    logic signed [ACC_W-1:0] row_d [N_CH];

    for (genvar r = 0; r < N_CH; r++) begin : g_row
        for (genvar k = 0; k < N_CH; k++) begin : g_col
            assign prod[r][k] =
                $signed({{(ACC_W-COEF_W){coef[r*N_CH+k][COEF_W-1]}}, coef[r*N_CH+k]}) *
                $signed({{(ACC_W-SUM_W){sum_in[k][SUM_W-1]}}, sum_in[k]});
        end
        assign row_d[r] = prod[r][0] + prod[r][1] + prod[r][2];
    end

    // Valid flag for stage 2
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_in;
    end

    // Row accumulators, captured for valid pixels only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N_CH; r++) acc_q[r] <= '0;
        end else if (v_in) begin
            acc_q <= row_d;
        end
    end
endmodule

// File: rtl/csc_round_clamp.sv
// Stage 3: adds the row offset, rounds half up and clamps to the pixel range.
// Offsets are in output LSBs and are shifted up by COEF_FRAC before the add.
module csc_round_clamp
    import csc_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int OFF_W = PIX_W + 1,
    parameter int ACC_W = 31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v_in,
    input  logic signed [ACC_W-1:0] acc_in [N_CH],
    input  logic signed [OFF_W-1:0] post   [N_CH],
    output logic                    v_q,
    output logic [PIX_W-1:0]        pix_q  [N_CH]
);
    localparam int TOT_W = ACC_W + 2;
    localparam logic signed [TOT_W-1:0] RND =
        {{(TOT_W-COEF_FRAC){1'b0}}, 1'b1, {(COEF_FRAC-1){1'b0}}};

    logic signed [TOT_W-1:0] tot   [N_CH];
    logic signed [TOT_W-1:0] shr   [N_CH];
    logic [PIX_W-1:0]        pix_d [N_CH];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign tot[c] = $signed({{(TOT_W-ACC_W){acc_in[c][ACC_W-1]}}, acc_in[c]}) +
                        ($signed({{(TOT_W-OFF_W){post[c][OFF_W-1]}}, post[c]}) <<< COEF_FRAC) +
                        RND;
        assign shr[c] = tot[c] >>> COEF_FRAC;
        assign pix_d[c] = shr[c][TOT_W-1]         ? '0 :
                          (|shr[c][TOT_W-2:PIX_W]) ? '1 :
                                                     shr[c][PIX_W-1:0];
    end

    // Output valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_in;
    end

    // Output pixels, updated for valid pixels only and held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CH; c++) pix_q[c] <= '0;
        end else if (v_in) begin
            pix_q <= pix_d;
        end
    end
endmodule

// File: rtl/csc_pipe.sv
// Top of the pipe colour matrix converter: out = M x (in + pre) + post,
// rounded and clamped, three clocks after the input.
// Assumes frame_start is pulsed only while no pixel is in the pipeline.
module csc_pipe
    import csc_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int COEF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [COEF_W-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_ch0,
    input  logic [PIX_W-1:0]  in_ch1,
    input  logic [PIX_W-1:0]  in_ch2,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_ch0,
    output logic [PIX_W-1:0]  out_ch1,
    output logic [PIX_W-1:0]  out_ch2
);
    localparam int OFF_W = PIX_W + 1;
    localparam int SUM_W = PIX_W + 2;
    localparam int ACC_W = SUM_W + COEF_W + 2;
    localparam int CFG_W = N_COEF * COEF_W + 2 * N_CH * OFF_W;

    logic signed [COEF_W-1:0] coef     [N_COEF];
    logic signed [OFF_W-1:0]  pre      [N_CH];
    logic signed [OFF_W-1:0]  post_eff [N_CH];
    logic [PIX_W-1:0]         in_pix   [N_CH];
    logic                     v1, v2;
    logic signed [SUM_W-1:0]  sum1     [N_CH];
    logic signed [ACC_W-1:0]  acc2     [N_CH];
    logic [PIX_W-1:0]         pix3     [N_CH];
    logic [CFG_W-1:0]         cfg_flat;

    assign in_pix[0] = in_ch0;
    assign in_pix[1] = in_ch1;
    assign in_pix[2] = in_ch2;

    csc_cfg_regs #(.PIX_W(PIX_W), .COEF_W(COEF_W), .OFF_W(OFF_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .coef_q(coef), .pre_q(pre), .post_eff(post_eff)
    );

    csc_pre_add #(.PIX_W(PIX_W), .OFF_W(OFF_W), .SUM_W(SUM_W)) u_s1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .pre(pre), .v_q(v1), .sum_q(sum1)
    );

    csc_matrix_mac #(.COEF_W(COEF_W), .SUM_W(SUM_W), .ACC_W(ACC_W)) u_s2 (
        .clk(clk), .rst_n(rst_n), .v_in(v1), .sum_in(sum1), .coef(coef),
        .v_q(v2), .acc_q(acc2)
    );

    csc_round_clamp #(.PIX_W(PIX_W), .OFF_W(OFF_W), .ACC_W(ACC_W)) u_s3 (
        .clk(clk), .rst_n(rst_n), .v_in(v2), .acc_in(acc2), .post(post_eff),
        .v_q(out_valid), .pix_q(pix3)
    );

    assign out_ch0 = pix3[0];
    assign out_ch1 = pix3[1];
    assign out_ch2 = pix3[2];

    // Flattened view of the active settings, observed by the checker
    for (genvar i = 0; i < N_COEF; i++) begin : g_fc
        assign cfg_flat[i*COEF_W +: COEF_W] = coef[i];
    end
    for (genvar i = 0; i < N_CH; i++) begin : g_fo
        assign cfg_flat[N_COEF*COEF_W + i*OFF_W +: OFF_W]          = pre[i];
        assign cfg_flat[N_COEF*COEF_W + (N_CH+i)*OFF_W +: OFF_W]   = post_eff[i];
    end
endmodule

// File: rtl/csc_pipe_chk.sv
// Protocol checker for csc_pipe, bound into every instance.
// A saturating count of cycles since reset keeps $past inside the
// post-reset window.
module csc_pipe_chk #(
    parameter int PIX_W = 12,
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             frame_start,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_ch0,
    input logic [PIX_W-1:0] out_ch1,
    input logic [PIX_W-1:0] out_ch2,
    input logic [CFG_W-1:0] cfg_flat
);
    logic [1:0] since_rst;

    // Counts clock edges since reset release, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !out_valid) |->
            ($stable(out_ch0) && $stable(out_ch1) && $stable(out_ch2)));

    p_cfg_frame_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !$past(frame_start)) |-> $stable(cfg_flat));

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst <= 2'd1) |->
            (!out_valid && out_ch0 == '0 && out_ch1 == '0 && out_ch2 == '0));
endmodule

bind csc_pipe csc_pipe_chk #(.PIX_W(PIX_W), .CFG_W(CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frame_start(frame_start),
    .out_valid(out_valid), .out_ch0(out_ch0), .out_ch1(out_ch1),
    .out_ch2(out_ch2), .cfg_flat(cfg_flat)
);

// File: tb/csc_pipe_tb.sv
`timescale 1ns/1ps
// Bench for csc_pipe: behavioural integer model, compared every clock.
module csc_pipe_tb_top;
    localparam real CLK_PERIOD = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [14:0] cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_ch0 = '0, in_ch1 = '0, in_ch2 = '0;
    logic        out_valid;
    logic [11:0] out_ch0, out_ch1, out_ch2;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state: staged and active settings
    int st_coef[9], ac_coef[9];
    int st_pre[3],  ac_pre[3];
    int st_post[3], ac_post[3];
    bit st_leg, st_yuv, st_blk, ac_leg, ac_yuv, ac_blk;

    // Expected pipeline, slot 2 is the oldest
    bit    ex_v[3];
    int    ex_d[3][3];
    string ex_tag[3];
    int    last_d[3];

    always #(CLK_PERIOD/2.0) clk = ~clk;

    csc_pipe dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_ch0(in_ch0), .in_ch1(in_ch1), .in_ch2(in_ch2),
        .out_valid(out_valid), .out_ch0(out_ch0), .out_ch1(out_ch1), .out_ch2(out_ch2)
    );

    function automatic int legacy_off(int row);
        if (!ac_yuv && !ac_blk) return (row == 1) ? 0 : 2048;
        if (!ac_yuv &&  ac_blk) return (row == 1) ? 256 : 2048;
        if ( ac_yuv && !ac_blk) return 0;
        return 256;
    endfunction

    function automatic int model_row(int row, int i0, int i1, int i2);
        longint a[3];
        longint t;
        int po;
        a[0] = i0 + ac_pre[0];
        a[1] = i1 + ac_pre[1];
        a[2] = i2 + ac_pre[2];
        t = 0;
        for (int k = 0; k < 3; k++) t += longint'(ac_coef[row*3+k]) * a[k];
        po = ac_leg ? legacy_off(row) : ac_post[row];
        t = t + longint'(po) * 4096 + 2048;
        t = t >>> 12;
        if (t < 0) return 0;
        if (t > 4095) return 4095;
        return int'(t);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 9; i++) begin
            st_coef[i] = (i % 4 == 0) ? 4096 : 0;
            ac_coef[i] = st_coef[i];
        end
        for (int i = 0; i < 3; i++) begin
            st_pre[i] = 0; ac_pre[i] = 0; st_post[i] = 0; ac_post[i] = 0;
            ex_v[i] = 1'b0; ex_tag[i] = "R10"; last_d[i] = 0;
            for (int j = 0; j < 3; j++) ex_d[i][j] = 0;
        end
        st_leg = 0; st_yuv = 0; st_blk = 0; ac_leg = 0; ac_yuv = 0; ac_blk = 0;
    endtask

    // One clock: compare outputs, then drive the next inputs and update the model
    task automatic step(input bit we, input int addr, input int data, input bit fs,
                        input bit v, input int p0, input int p1, input int p2,
                        input string tag);
        int e[3];
        @(negedge clk);
        if (ex_v[2]) for (int c = 0; c < 3; c++) last_d[c] = ex_d[2][c];
        for (int c = 0; c < 3; c++) e[c] = last_d[c];
        n_vec++;
        if (out_valid !== ex_v[2] || out_ch0 !== e[0][11:0] ||
            out_ch1 !== e[1][11:0] || out_ch2 !== e[2][11:0]) begin
            n_bad++;
            $display("FAIL %s: got v=%0b %0d %0d %0d expected v=%0b %0d %0d %0d",
                     ex_tag[2], out_valid, out_ch0, out_ch1, out_ch2,
                     ex_v[2], e[0], e[1], e[2]);
        end
        for (int s = 2; s > 0; s--) begin
            ex_v[s] = ex_v[s-1]; ex_tag[s] = ex_tag[s-1];
            for (int c = 0; c < 3; c++) ex_d[s][c] = ex_d[s-1][c];
        end
        ex_v[0] = v;
        ex_tag[0] = tag;
        if (v) for (int r = 0; r < 3; r++) ex_d[0][r] = model_row(r, p0, p1, p2);
        cfg_we = we; cfg_addr = addr[3:0]; cfg_wdata = data[14:0];
        frame_start = fs; in_valid = v;
        in_ch0 = p0[11:0]; in_ch1 = p1[11:0]; in_ch2 = p2[11:0];
        if (fs) begin
            ac_coef = st_coef; ac_pre = st_pre; ac_post = st_post;
            ac_leg = st_leg; ac_yuv = st_yuv; ac_blk = st_blk;
        end
        if (we) begin
            if (addr < 9)        st_coef[addr]    = int'($signed(data[14:0]));
            else if (addr < 12)  st_pre[addr-9]   = int'($signed(data[12:0]));
            else if (addr < 15)  st_post[addr-12] = int'($signed(data[12:0]));
            else begin st_leg = data[0]; st_yuv = data[1]; st_blk = data[2]; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    endtask
    task automatic wr(input int a, input int d);
        step(1, a, d, 0, 0, 0, 0, 0, "R5");
    endtask
    task automatic px(input int a, input int b, input int c, input string tag);
        step(0, 0, 0, 0, 1, a, b, c, tag);
    endtask
    task automatic apply();
        idle(3);
        step(0, 0, 0, 1, 0, 0, 0, 0, "R6");
    endtask
    task automatic set_matrix(input int c0, input int c1, input int c2, input int c3,
                              input int c4, input int c5, input int c6, input int c7,
                              input int c8);
        wr(0, c0); wr(1, c1); wr(2, c2); wr(3, c3); wr(4, c4);
        wr(5, c5); wr(6, c6); wr(7, c7); wr(8, c8);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R10: reset state
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        rst_n = 1'b1;
        idle(2);

        // R7: identity pass-through after reset, R1 back-to-back and gaps
        px(0, 0, 0, "R7");
        px(4095, 4095, 4095, "R7");
        px(100, 2000, 3000, "R1");
        idle(2);
        px(7, 8, 9, "R1");
        idle(4);

        // R6: staged writes invisible until frame start; write in the fs cycle deferred
        set_matrix(0, 0, 4096, 4096, 0, 0, 0, 0, 0);
        px(11, 22, 33, "R6");
        idle(3);
        step(1, 7, 4096, 1, 0, 0, 0, 0, "R6");
        px(11, 22, 33, "R6");
        px(1000, 2000, 3000, "R2");
        apply();
        px(11, 22, 33, "R2");
        px(1000, 2000, 3000, "R2");
        idle(3);

        // R3: half-up rounding with 0.5 on the diagonal
        set_matrix(2048, 0, 0, 0, 2048, 0, 0, 0, 2048);
        apply();
        px(1, 3, 5, "R3");
        px(0, 4095, 2, "R3");
        idle(3);

        // R4: clamp high and low
        set_matrix(16383, 0, 0, 0, 16384, 0, 0, 0, 4096);
        apply();
        px(4095, 1000, 50, "R4");
        px(1, 1, 4095, "R4");
        idle(3);

        // R5/R2: mixed-sign matrix, pre offsets, explicit post offsets of 257
        set_matrix(2048, 31744, 1024, 30720, 6144, 512, 0, 32256, 5120);
        wr(9, 16'h1F00); wr(10, 16'h1800); wr(11, 16'h1800);
        wr(12, 257); wr(13, 257); wr(14, 257);
        apply();
        px(2048, 2048, 2048, "R5");
        px(300, 3500, 900, "R2");
        px(4095, 0, 4095, "R2");
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(0, 3) == 0) idle(1);
            px(int'($urandom_range(0, 4095)), int'($urandom_range(0, 4095)),
               int'($urandom_range(0, 4095)), "R1");
        end
        idle(3);

        // R8: legacy table, explicit post registers (257) ignored
        set_matrix(4096, 0, 0, 0, 4096, 0, 0, 0, 4096);
        wr(9, 0); wr(10, 0); wr(11, 0);
        for (int m = 0; m < 4; m++) begin
            wr(15, 1 | (m << 1));
            apply();
            px(1000, 1000, 1000, "R8");
            px(4000, 100, 4000, "R8");
            idle(3);
        end

        // R7: back to explicit mode with zero offsets is a no-op
        wr(15, 0); wr(12, 0); wr(13, 0); wr(14, 0);
        apply();
        px(123, 2345, 3999, "R7");
        idle(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule